// File: doc/BRIEF.md
# Nibble-Parallel CRC5 Engine

This block keeps a 5-bit cyclic redundancy remainder for the generator x^5 + x^2 + 1 and advances it by four message bits in every clock cycle that carries data. It does this with fixed XOR next-state equations rather than a one-bit-per-clock shift register. The result is the same remainder that four serial shifts would produce, fed most significant nibble bit first.

A frame opens with a start strobe, which presets the remainder to all ones. Payload nibbles follow, each marked by a valid strobe. On the sending side the remainder on `crc_o` is the code to transmit.

On the receiving side the same engine recomputes the remainder over the received payload. A compare strobe then presents the received code. One cycle later the error output shows whether the two differ, and it keeps that verdict until the next frame opens.

Top module: `crc5n_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `crc_o` becomes 5'h1F and `err_o` becomes 0.
- R2: A cycle with `start_i` high sets `crc_o` to 5'h1F at the next edge. This holds even when `valid_i` is high in the same cycle, and that cycle's nibble is dropped.
- R3: In a cycle with `valid_i` low and `start_i` low, `crc_o` keeps its value, whatever `nib_i` carries.
- R4: In a cycle with `valid_i` high and `start_i` low, the next `crc_o` is given by these equations, with c the current value and d = `nib_i`: n0=c1^c4^d0^d3, n1=c2^d1, n2=c1^c3^c4^d0^d2^d3, n3=c2^c4^d1^d3, n4=c0^c3^d2. This equals four serial steps fed d3, d2, d1, d0 in that order. Each step uses f = c4^bit and gives {c3, c2, c1^f, c0, f}.
- R5: In a cycle with `chk_i` high and `start_i` low, `err_o` at the next edge becomes 1 if that cycle's `crc_o` differs from `rx_crc_i`, and 0 if they are equal. A nibble absorbed in the same cycle does not take part in the comparison.
- R6: `err_o` keeps its value until the next `start_i` or compare strobe. A start clears it to 0 at the next edge, and start takes priority over a compare in the same cycle.
- R7: A payload that differs from the transmitted payload in exactly one bit, checked against the code of the transmitted payload, gives `err_o` = 1. An unaltered payload gives `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a frame: presets the remainder and clears the error |
| valid_i | input | 1 | `nib_i` carries a payload nibble this cycle |
| nib_i | input | 4 | Payload nibble; bit 3 is the earliest bit on the wire |
| chk_i | input | 1 | Compare strobe marking the end of the payload |
| rx_crc_i | input | 5 | Received code, sampled while `chk_i` is high |
| crc_o | output | 5 | Current remainder |
| err_o | output | 1 | Registered mismatch verdict |

## Verification
The bench builds the engine with its default preset of 5'h1F and a 4-bit data path, the only width the equations cover. With those values, every per-nibble result can be checked against a one-bit-per-clock shift model started from the same preset, over both table-driven and random frames. The same defaults let the bench confirm that every single-bit corruption of a 16-bit payload flips the verdict. They also make it possible to see whether start, valid and compare are ordered correctly when they land in the same cycle.

// File: rtl/crc5n_pkg.sv
package crc5n_pkg;

  localparam int CRC_W = 5;
  localparam int NIB_W = 4;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;

  // Four message bits folded into the remainder in one step; bit 3 of the
  // nibble is the first bit on the wire.
  function automatic crc_t nib_next(input crc_t c, input nib_t d);
    crc_t n;
    n[0] = c[1] ^ c[4] ^ d[0] ^ d[3];
    n[1] = c[2] ^ d[1];
    n[2] = c[1] ^ c[3] ^ c[4] ^ d[0] ^ d[2] ^ d[3];
    n[3] = c[2] ^ c[4] ^ d[1] ^ d[3];
    n[4] = c[0] ^ c[3] ^ d[2];
    return n;
  endfunction

  // Verdict of a comparison: 1 means the codes differ.
  function automatic logic code_differs(input crc_t mine, input crc_t theirs);
    return |(mine ^ theirs);
  endfunction

endpackage

// File: rtl/crc5n_step.sv
module crc5n_step
  import crc5n_pkg::*;
(
  input  crc_t cur,
  input  nib_t dat,
  output crc_t nxt
);
  assign nxt = nib_next(cur, dat);
endmodule

// File: rtl/crc5n_reg.sv
module crc5n_reg
  import crc5n_pkg::*;
#(
  parameter crc_t PRESET = 5'h1F
)(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic adv,
  input  crc_t nxt,
  output crc_t q
);
  always_ff @(posedge clk) begin
    if (rst || load) q <= PRESET;
    else if (adv)    q <= nxt;
  end
endmodule

// File: rtl/crc5n_cmp.sv
module crc5n_cmp
  import crc5n_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cmp,
  input  crc_t cur,
  input  crc_t rx,
  output logic miss,
  output logic err
);
  assign miss = code_differs(cur, rx);

  always_ff @(posedge clk) begin
    if (rst || clr) err <= 1'b0;
    else if (cmp)   err <= miss;
  end
endmodule

// File: rtl/crc5n_engine.sv
module crc5n_engine
  import crc5n_pkg::*;
#(
  parameter logic [4:0] PRESET = 5'h1F
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       valid_i,
  input  logic [3:0] nib_i,
  input  logic       chk_i,
  input  logic [4:0] rx_crc_i,
  output logic [4:0] crc_o,
  output logic       err_o
);
  // Named internal events, visible to the bound checker.
  crc_t step_nxt;
  logic do_adv;
  logic do_cmp;
  logic miss;

  assign do_adv = valid_i & ~start_i;
  assign do_cmp = chk_i & ~start_i;

  crc5n_step u_step (
    .cur (crc_o),
    .dat (nib_i),
    .nxt (step_nxt)
  );

  crc5n_reg #(.PRESET(PRESET)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (start_i),
    .adv  (do_adv),
    .nxt  (step_nxt),
    .q    (crc_o)
  );

  crc5n_cmp u_cmp (
    .clk  (clk),
    .rst  (rst),
    .clr  (start_i),
    .cmp  (do_cmp),
    .cur  (crc_o),
    .rx   (rx_crc_i),
    .miss (miss),
    .err  (err_o)
  );
endmodule

// File: rtl/crc5n_engine_chk.sv
module crc5n_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       valid_i,
  input logic       chk_i,
  input logic [4:0] rx_crc_i,
  input logic [4:0] crc_o,
  input logic       err_o,
  input logic [4:0] step_nxt
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (crc_o == 5'h1F && !err_o));

  assert_preset_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> crc_o == 5'h1F);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !valid_i) |=> $stable(crc_o));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (!start_i && valid_i) |=> crc_o == $past(step_nxt));

  assert_verdict_R5: assert property (@(posedge clk) disable iff (rst)
    (!start_i && chk_i) |=> err_o == ($past(crc_o) != $past(rx_crc_i)));

  assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !chk_i) |=> $stable(err_o));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !err_o);
endmodule

bind crc5n_engine crc5n_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .valid_i  (valid_i),
  .chk_i    (chk_i),
  .rx_crc_i (rx_crc_i),
  .crc_o    (crc_o),
  .err_o    (err_o),
  .step_nxt (step_nxt)
);

// File: tb/crc5n_engine_bench.sv
module crc5n_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic       chk_i = 1'b0;
  logic [4:0] rx_crc_i = 5'h00;
  logic [4:0] crc_o;
  logic       err_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  crc5n_engine u_crc5n_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
    .nib_i(nib_i), .chk_i(chk_i), .rx_crc_i(rx_crc_i),
    .crc_o(crc_o), .err_o(err_o)
  );

  // {payload, flipped bits}: the payload is sent with the flips applied and
  // checked against the code of the clean payload.
  localparam int NVEC = 10;
  localparam logic [31:0] VECS [NVEC] = '{
    {16'h0000, 16'h0000}, {16'hFFFF, 16'h0000}, {16'hA5C3, 16'h0000},
    {16'h1234, 16'h0001}, {16'h1234, 16'h8000}, {16'hBEEF, 16'h0100},
    {16'h0F0F, 16'h0020}, {16'h7E81, 16'h0000}, {16'hC001, 16'h0004},
    {16'h5A5A, 16'h1000}
  };

  // One serial shift of x^5 + x^2 + 1.
  function automatic logic [4:0] ser_bit(input logic [4:0] s, input logic b);
    logic f;
    f = s[4] ^ b;
    return {s[3], s[2], s[1] ^ f, s[0], f};
  endfunction

  function automatic logic [4:0] ser_nib(input logic [4:0] s, input logic [3:0] n);
    logic [4:0] t;
    t = s;
    for (int i = 3; i >= 0; i--) t = ser_bit(t, n[i]);
    return t;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [3:0] n);
    valid_i = 1'b1;
    nib_i = n;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic compare(input logic [4:0] code);
    chk_i = 1'b1;
    rx_crc_i = code;
    @(negedge clk);
    chk_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] model;
    logic [4:0] good;
    logic [4:0] held;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset crc", crc_o, 5'h1F);
    check("R1 reset err", {4'b0, err_o}, 5'h00);

    // Table of frames.
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] msg;
      logic [15:0] flip;
      logic [15:0] sent;
      msg  = VECS[v][31:16];
      flip = VECS[v][15:0];
      sent = msg ^ flip;
      good = 5'h1F;
      for (int k = 3; k >= 0; k--) good = ser_nib(good, msg[k*4 +: 4]);
      pulse_start();
      check("R2 preset", crc_o, 5'h1F);
      model = 5'h1F;
      for (int k = 3; k >= 0; k--) begin
        send(sent[k*4 +: 4]);
        model = ser_nib(model, sent[k*4 +: 4]);
        check("R4 table nibble", crc_o, model);
      end
      compare(good);
      check("R7 verdict", {4'b0, err_o}, {4'b0, flip != 16'h0});
      repeat (2) @(negedge clk);
      check("R6 verdict held", {4'b0, err_o}, {4'b0, flip != 16'h0});
    end

    // Every single-bit corruption of one payload.
    for (int b = 0; b < 16; b++) begin
      logic [15:0] sent;
      sent = 16'h3C96 ^ (16'h1 << b);
      good = 5'h1F;
      for (int k = 3; k >= 0; k--) good = ser_nib(good, 16'h3C96 >> (k*4));
      pulse_start();
      for (int k = 3; k >= 0; k--) send(sent[k*4 +: 4]);
      compare(good);
      check("R7 single flip", {4'b0, err_o}, 5'h01);
    end

    // Hold while valid is low, with the nibble toggling.
    pulse_start();
    send(4'h9);
    held = ser_nib(5'h1F, 4'h9);
    for (int i = 0; i < 3; i++) begin
      nib_i = 4'(i * 5 + 3);
      @(negedge clk);
      check("R3 hold", crc_o, held);
    end

    // Start and valid together: nibble dropped.
    start_i = 1'b1;
    valid_i = 1'b1;
    nib_i = 4'hB;
    @(negedge clk);
    start_i = 1'b0;
    valid_i = 1'b0;
    check("R2 start beats valid", crc_o, 5'h1F);

    // Compare and valid together: compare sees the pre-update value.
    send(4'h6);
    model = ser_nib(5'h1F, 4'h6);
    valid_i = 1'b1;
    nib_i = 4'hD;
    chk_i = 1'b1;
    rx_crc_i = model;
    @(negedge clk);
    valid_i = 1'b0;
    chk_i = 1'b0;
    check("R5 compare uses pre-update value", {4'b0, err_o}, 5'h00);
    check("R4 absorbed beside compare", crc_o, ser_nib(model, 4'hD));
    compare(~crc_o);
    check("R5 mismatch", {4'b0, err_o}, 5'h01);
    compare(crc_o);
    check("R5 match after mismatch", {4'b0, err_o}, 5'h00);
    compare(crc_o ^ 5'h10);
    check("R5 mismatch again", {4'b0, err_o}, 5'h01);

    // Start and compare together: start wins and clears.
    start_i = 1'b1;
    chk_i = 1'b1;
    rx_crc_i = 5'h00;
    @(negedge clk);
    start_i = 1'b0;
    chk_i = 1'b0;
    check("R6 start clears err", {4'b0, err_o}, 5'h00);
    check("R2 start with compare", crc_o, 5'h1F);

    // Random streams against the serial model.
    for (int s = 0; s < 20; s++) begin
      pulse_start();
      model = 5'h1F;
      for (int k = 0; k < 8; k++) begin
        logic [3:0] n;
        n = 4'($urandom);
        send(n);
        model = ser_nib(model, n);
        check("R4 random nibble", crc_o, model);
        if (($urandom & 3) == 0) @(negedge clk);
      end
      compare(model);
      check("R5 random match", {4'b0, err_o}, 5'h00);
    end

    // Reset mid-frame.
    send(4'h2);
    compare(5'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset crc mid-frame", crc_o, 5'h1F);
    check("R1 reset err mid-frame", {4'b0, err_o}, 5'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule